// File: doc/BRIEF.md
# Reloading Countdown Timer Bank

This block holds four countdown timers and the small register set that controls them. Software reaches the block through a 32-bit memory-mapped port with byte strobes. Timers one and two are 16 bits wide and share one 32-bit load register, with one half for each timer. Timers three and four are 32 bits wide and each has a load register of its own. A control register holds one run bit per timer. A read-only word returns the live counts of the two narrow timers, packed the same way as their shared load register.

Register writes happen in the bus clock domain. The timers run on a separate timer clock. A toggle handshake carries each load request across the two domains. When a timer receives a load request, it copies its load register a few timer-clock edges after the write, whether or not it is running. A running timer counts down by one on each timer-clock edge. When the count is at zero, the next edge copies the stored load value back into the timer and raises a one-cycle terminal pulse. The period is therefore the load value plus one.

Top module: `tmr_bank_regs`

## Requirements
- R1: After reset, every register reads zero, every count is zero and no terminal pulse is raised.
- R2: The shared load register sits at offset 0x10. Bits 15..0 hold the timer-one load value and bits 31..16 hold the timer-two load value. A read returns the stored word.
- R3: Byte strobe k (wr_strb[k]) enables data bits 8k+7..8k. A write that touches only one half loads only the timer that owns that half. A write with no strobe set changes nothing.
- R4: The 32-bit load registers of timers three and four sit at offsets 0x14 and 0x18, and each reads back its last written value.
- R5: A write to a load register makes the timer it touches take the written value, even while that timer is stopped.
- R6: A stopped timer keeps its count.
- R7: A running timer counts down by one on each timer-clock edge.
- R8: When a running timer is at zero, the next edge reloads the stored value and raises a terminal pulse lasting one timer-clock cycle. With load value L, the pulses come every L+1 edges.
- R9: Offset 0x20 reads the live count of timer two in bits 31..16 and the live count of timer one in bits 15..0.
- R10: The control register sits at offset 0x00. Bit i-1 runs timer i, the upper bits read zero, and a write needs strobe 0.
- R11: Each accepted load write reaches the timer domain exactly once, and the timer then holds the written value rather than a stale or repeated one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register port clock |
| bus_rst_n | input | 1 | Asynchronous active-low reset, bus domain |
| bus_we | input | 1 | Write request |
| bus_waddr | input | 6 | Write byte offset |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte strobes for the write |
| bus_raddr | input | 6 | Read byte offset |
| bus_rdata | output | 32 | Read data for bus_raddr |
| tmr_clk | input | 1 | Timer clock |
| tmr_rst_n | input | 1 | Asynchronous active-low reset, timer domain |
| tmr_tc | output | 4 | Terminal pulses; bit i-1 belongs to timer i |

## Verification
A sequence of writes to the shared register tries every strobe pattern: a full word, the low half only, the high half only, no strobes, and single bytes. After each write the bench reads back both the stored word and the live counts of the stopped timers. This separates a write that wrongly reaches the other half, a write that is dropped, and a load that was never forwarded to the timer. Load values of 2, 3, 4 and 5 on the four timers give four different pulse spacings, and each spacing is measured in timer-clock edges, so an off-by-one in the reload or a wrong lane is visible. A partly run, then stopped, timer shows the countdown direction, shows that a stopped timer holds, and shows that a forced load overrides the count it had.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;
  localparam int NUM_TMR = 4;
  localparam int DATA_W  = 32;
  localparam int STRB_W  = DATA_W / 8;
  localparam int ADDR_W  = 6;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_LD12 = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_LD3  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_LD4  = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_CC12 = 6'h20;

  function automatic logic [DATA_W-1:0] strb_merge(
    input logic [DATA_W-1:0] old_v,
    input logic [DATA_W-1:0] new_v,
    input logic [STRB_W-1:0] strb
  );
    logic [DATA_W-1:0] r;
    for (int b = 0; b < STRB_W; b++) begin
      r[8*b +: 8] = strb[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/tmr_bit_sync.sv
module tmr_bit_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/tmr_toggle_sync.sv
module tmr_toggle_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= tgl_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign pulse = s2_q ^ s3_q;
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         ld_stb,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         tc
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         tc_q, tc_d;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    tc_d  = 1'b0;
    if (ld_stb) begin
      cnt_d = ld_val;
    end else if (en) begin
      if (at_zero) begin
        cnt_d = ld_val;
        tc_d  = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tc_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tc_q  <= tc_d;
    end
  end

  assign cnt = cnt_q;
  assign tc  = tc_q;

  AST_LOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |=> (cnt_q == $past(ld_val)));  // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_stb && !en) |=> $stable(cnt_q));  // R6
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_stb && en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1) && !tc_q);  // R7
  AST_RELOAD_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_stb && en && cnt_q == '0) |=> (cnt_q == $past(ld_val)) && tc_q);  // R8
endmodule

// File: rtl/tmr_bank_regs.sv
module tmr_bank_regs
  import tmr_bank_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_waddr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [STRB_W-1:0] bus_wstrb,
  input  logic [ADDR_W-1:0] bus_raddr,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tmr_clk,
  input  logic              tmr_rst_n,
  output logic [NUM_TMR-1:0] tmr_tc
);
  localparam int HALF_STRB = STRB_W / 2;

  logic bus_rst_sn, tmr_rst_sn;

  tmr_bit_sync u_bus_rst (.clk(bus_clk), .rst_n(bus_rst_n), .d(1'b1), .q(bus_rst_sn));
  tmr_bit_sync u_tmr_rst (.clk(tmr_clk), .rst_n(tmr_rst_n), .d(1'b1), .q(tmr_rst_sn));

  // Bus-domain register state
  logic [NUM_TMR-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0]  ld12_q, ld12_d, ld3_q, ld3_d, ld4_q, ld4_d;
  logic [NUM_TMR-1:0] req_q, req_d;
  logic               wr_ctrl, wr_ld12, wr_ld3, wr_ld4, any_strb;
  logic               hit_lo, hit_hi;

  always_comb begin
    any_strb = |bus_wstrb;
    wr_ctrl  = bus_we && (bus_waddr == OFS_CTRL) && bus_wstrb[0];
    wr_ld12  = bus_we && (bus_waddr == OFS_LD12) && any_strb;
    wr_ld3   = bus_we && (bus_waddr == OFS_LD3)  && any_strb;
    wr_ld4   = bus_we && (bus_waddr == OFS_LD4)  && any_strb;
    hit_lo   = wr_ld12 && (|bus_wstrb[HALF_STRB-1:0]);
    hit_hi   = wr_ld12 && (|bus_wstrb[STRB_W-1:HALF_STRB]);
    ctrl_d   = bus_wdata[NUM_TMR-1:0];
    ld12_d   = strb_merge(ld12_q, bus_wdata, bus_wstrb);
    ld3_d    = strb_merge(ld3_q,  bus_wdata, bus_wstrb);
    ld4_d    = strb_merge(ld4_q,  bus_wdata, bus_wstrb);
    req_d    = req_q ^ {wr_ld4, wr_ld3, hit_hi, hit_lo};
  end

  always_ff @(posedge bus_clk or negedge bus_rst_sn) begin
    if (!bus_rst_sn) begin
      ctrl_q <= '0;
      ld12_q <= '0;
      ld3_q  <= '0;
      ld4_q  <= '0;
      req_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_ld12) ld12_q <= ld12_d;
      if (wr_ld3)  ld3_q  <= ld3_d;
      if (wr_ld4)  ld4_q  <= ld4_d;
      req_q <= req_d;
    end
  end

  // Timer domain
  logic [NARROW_W-1:0] cnt_lo, cnt_hi;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam int W = (i < 2) ? NARROW_W : WIDE_W;
    logic         en_s, ld_pulse;
    logic [W-1:0] ld_w, cnt_w;

    tmr_bit_sync u_en_sync (
      .clk(tmr_clk), .rst_n(tmr_rst_sn), .d(ctrl_q[i]), .q(en_s));

    tmr_toggle_sync u_req_sync (
      .clk(tmr_clk), .rst_n(tmr_rst_sn), .tgl_in(req_q[i]), .pulse(ld_pulse));

    if (i == 0) begin : g_src
      assign ld_w = ld12_q[NARROW_W-1:0];
      assign cnt_lo = cnt_w;
    end else if (i == 1) begin : g_src
      assign ld_w = ld12_q[2*NARROW_W-1:NARROW_W];
      assign cnt_hi = cnt_w;
    end else if (i == 2) begin : g_src
      assign ld_w = ld3_q[W-1:0];
    end else begin : g_src
      assign ld_w = ld4_q[W-1:0];
    end

    tmr_down_counter #(.W(W)) u_cnt (
      .clk(tmr_clk), .rst_n(tmr_rst_sn), .en(en_s), .ld_stb(ld_pulse),
      .ld_val(ld_w), .cnt(cnt_w), .tc(tmr_tc[i]));
  end

  // Read port
  always_comb begin
    unique case (bus_raddr)
      OFS_CTRL: bus_rdata = DATA_W'(ctrl_q);
      OFS_LD12: bus_rdata = ld12_q;
      OFS_LD3:  bus_rdata = ld3_q;
      OFS_LD4:  bus_rdata = ld4_q;
      OFS_CC12: bus_rdata = {cnt_hi, cnt_lo};
      default:  bus_rdata = '0;
    endcase
  end

  AST_NO_STRB_NO_REQ: assert property (@(posedge bus_clk) disable iff (!bus_rst_sn)
    (bus_we && bus_wstrb == '0) |=> $stable(req_q) && $stable(ld12_q));  // R3
  AST_LOW_HALF_ONLY: assert property (@(posedge bus_clk) disable iff (!bus_rst_sn)
    (bus_we && bus_waddr == OFS_LD12 && bus_wstrb == 4'b0011)
      |=> (ld12_q[31:16] == $past(ld12_q[31:16])) && (req_q[1] == $past(req_q[1])));  // R3
  AST_ONE_REQ_PER_WRITE: assert property (@(posedge bus_clk) disable iff (!bus_rst_sn)
    !bus_we |=> $stable(req_q));  // R11
endmodule

// File: tb/tmr_bank_regs_bench.sv
module tmr_bank_regs_bench;
  logic        bus_clk = 1'b0, tmr_clk = 1'b0;
  logic        bus_rst_n, tmr_rst_n;
  logic        bus_we;
  logic [5:0]  bus_waddr, bus_raddr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  bus_wstrb, tmr_tc;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 bus_clk = ~bus_clk;
  always #7 tmr_clk = ~tmr_clk;

  tmr_bank_regs u_tmr_bank_regs (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_we(bus_we),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
    .bus_raddr(bus_raddr), .bus_rdata(bus_rdata), .tmr_clk(tmr_clk),
    .tmr_rst_n(tmr_rst_n), .tmr_tc(tmr_tc));

  // strobe, write data, expected word at 0x10 and at 0x20 (timers stopped)
  localparam logic [67:0] VEC [6] = '{
    {4'hF, 32'h1234_5678, 32'h1234_5678},
    {4'h3, 32'hAAAA_BBBB, 32'h1234_BBBB},
    {4'hC, 32'hCCCC_DDDD, 32'hCCCC_BBBB},
    {4'h0, 32'h1111_2222, 32'hCCCC_BBBB},
    {4'h1, 32'h0000_00EE, 32'hCCCC_BBEE},
    {4'h8, 32'h7700_0000, 32'h77CC_BBEE}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge bus_clk);
    bus_we = 1'b1; bus_waddr = a; bus_wdata = d; bus_wstrb = s;
    @(negedge bus_clk);
    bus_we = 1'b0; bus_wstrb = 4'h0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge bus_clk);
    bus_raddr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (12) @(negedge bus_clk);
  endtask

  task automatic period(input int idx, output int n);
    int g = 0;
    do begin @(negedge tmr_clk); g++; end while (!tmr_tc[idx] && g < 2000);
    n = 0;
    do begin @(negedge tmr_clk); n++; end while (!tmr_tc[idx] && n < 2000);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int p;
    bus_rst_n = 1'b0; tmr_rst_n = 1'b0; bus_we = 1'b0;
    bus_waddr = '0; bus_raddr = '0; bus_wdata = '0; bus_wstrb = '0;
    repeat (4) @(negedge bus_clk);
    bus_rst_n = 1'b1; tmr_rst_n = 1'b1;
    settle();

    // R1 reset state
    rd(6'h00, v); check("R1 ctrl", v, 32'h0);
    rd(6'h10, v); check("R1 ld12", v, 32'h0);
    rd(6'h18, v); check("R1 ld4", v, 32'h0);
    rd(6'h20, v); check("R1 cc12", v, 32'h0);
    check("R1 tc", {28'h0, tmr_tc}, 32'h0);

    // R2 R3 R5 R9 R11: strobe patterns on the shared register
    for (int k = 0; k < 6; k++) begin
      wr(6'h10, VEC[k][63:32], VEC[k][67:64]);
      settle();
      rd(6'h10, v); check($sformatf("R2 R3 readback vec%0d", k), v, VEC[k][31:0]);
      rd(6'h20, v); check($sformatf("R5 R9 R11 count vec%0d", k), v, VEC[k][31:0]);
    end

    // R6 stopped timers keep their counts
    repeat (30) @(negedge bus_clk);
    rd(6'h20, v); check("R6 hold", v, 32'h77CC_BBEE);

    // R4 wide load registers
    wr(6'h14, 32'h0000_0005, 4'hF);
    wr(6'h18, 32'hDEAD_0002, 4'hF);
    rd(6'h14, v); check("R4 ld3", v, 32'h0000_0005);
    rd(6'h18, v); check("R4 ld4", v, 32'hDEAD_0002);
    wr(6'h18, 32'h0000_0000, 4'hC);
    rd(6'h18, v); check("R4 R3 ld4 upper bytes", v, 32'h0000_0002);

    // R10 control register
    wr(6'h00, 32'hFFFF_FFF0, 4'hE);
    rd(6'h00, v); check("R10 no strobe0", v, 32'h0);
    wr(6'h12, 32'h0000_0000, 4'hF);
    rd(6'h10, v); check("R2 unmapped offset", v, 32'h77CC_BBEE);

    // R8 pulse spacing = load + 1
    wr(6'h10, 32'h0003_0004, 4'hF);
    settle();
    wr(6'h00, 32'hFFFF_FFFF, 4'h1);
    rd(6'h00, v); check("R10 readback", v, 32'h0000_000F);
    period(0, p); check("R8 timer1 period", p, 5);
    period(1, p); check("R8 timer2 period", p, 4);
    period(2, p); check("R8 timer3 period", p, 6);
    period(3, p); check("R8 timer4 period", p, 3);
    @(negedge tmr_clk); check("R8 one-cycle pulse", {31'h0, tmr_tc[3]}, 32'h0);

    // R7 countdown, then R6 hold and R5 forced load while stopped
    wr(6'h00, 32'h0, 4'h1);
    wr(6'h10, 32'h0000_03E8, 4'h3);
    settle();
    rd(6'h20, v); check("R5 stopped load", {16'h0, v[15:0]}, 32'h0000_03E8);
    wr(6'h00, 32'h1, 4'h1);
    repeat (20) @(negedge bus_clk);
    wr(6'h00, 32'h0, 4'h1);
    settle();
    rd(6'h20, v);
    check("R7 counted down", {31'h0, (v[15:0] < 16'd1000) && (v[15:0] > 16'd960)}, 32'h1);
    repeat (20) @(negedge bus_clk);
    rd(6'h20, v2); check("R6 hold after stop", v2, v);
    wr(6'h10, 32'hFFFF_0042, 4'h3);
    settle();
    rd(6'h20, v2); check("R5 R3 override low only", v2, {v[31:16], 16'h0042});

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule